// File: doc/BRIEF.md
# Trigger Busy Generator with Burst Interlock

This block drives a BUSY line back to a trigger source so that the source stops sending while the readout side cannot take more events. Each accepted L1 trigger opens a hold window. The window is a programmable number of coarse ticks, and a tick is a fixed number of system clock cycles (400 by default, which is 10 us at a 25 ns clock). BUSY is also forced high while the downstream buffers report full, so a hold window cannot end and drop BUSY while storage is exhausted.

A leaky-bucket burst limiter sits alongside the hold timer. Every trigger pours one unit into the bucket. BUSY is forced high while the bucket level is at the programmed burst size. The bucket drains one unit each time a programmable number of ticks passes. A burst size of zero switches the limiter off and empties the bucket. A 32-bit counter totals the clock cycles in which BUSY is high. A synchronous strobe clears this counter.

The block has no data streams. All pins are plain control or status levels and strobes, so there is no valid/ready handshake and no back-pressure.

Top module: `busy_gen`

## Requirements
- R1: After reset, with `full_i` low, `busy_o` is 0 and `busy_cycles_o` is 0.
- R2: A cycle with `trig_i` high and `cfg_hold_ticks` non-zero makes `busy_o` high from the next cycle. `busy_o` stays high until `cfg_hold_ticks` tick boundaries have passed. A tick boundary is every `CYCLES_PER_TICK`-th cycle of a free-running prescaler that starts at reset.
- R3: A trigger that arrives while a hold window is running reloads the remaining hold to `cfg_hold_ticks`.
- R4: A trigger with `cfg_hold_ticks` equal to 0 opens no hold window.
- R5: While `full_i` is high, `busy_o` is high in the same cycle, whatever the other state is.
- R6: With a non-zero `cfg_burst_size`, each trigger raises the bucket level by one, up to the burst size. `busy_o` is high whenever the level is at or above the burst size.
- R7: On a tick boundary with a non-empty bucket, the leak timer advances by one. When it reaches `cfg_leak_ticks`, the level drops by one and the leak timer restarts. A value of 0 or 1 drains one unit every tick. With an empty bucket the leak timer stays at zero.
- R8: `cfg_burst_size` equal to 0 disables the limiter. The bucket is held empty, and any number of triggers adds no busy time of its own.
- R9: `busy_cycles_o` increases by one after every cycle in which `busy_o` is high. It holds its value after cycles in which `busy_o` is low, and wraps at 2^32.
- R10: `cnt_clr_i` clears `busy_cycles_o` to 0 on the next edge, with priority over counting, and does not change `busy_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | L1 trigger pulse, one cycle per trigger |
| full_i | input | 1 | Downstream buffers full |
| cfg_hold_ticks | input | 16 | Hold window length in ticks |
| cfg_burst_size | input | 6 | Bucket limit; 0 disables the limiter |
| cfg_leak_ticks | input | 16 | Ticks per bucket drain step |
| cnt_clr_i | input | 1 | Synchronous clear of the busy-time counter |
| busy_o | output | 1 | BUSY to the trigger source |
| busy_cycles_o | output | 32 | Number of cycles BUSY has been high |

## Verification
A hold counter or bucket level that has gone wrong inside the block shows at `busy_o` as a window that is too short, too long or missing. With the bench's short tick, this appears within one tick of the expected edge. A miscounting busy-time counter diverges from the reference on the first cycle after the mistake, because the count is compared on every clock. The bucket level shows at the port only once it crosses the burst size. For that reason the bench drives sequences that fill the bucket exactly to the limit and then watches the drain release BUSY at the predicted tick.

// File: rtl/busy_gen_pkg.sv
package busy_gen_pkg;
  parameter int unsigned TICK_CYCLES_DEFAULT = 400;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/busy_tick_gen.sv
module busy_tick_gen #(
  parameter int unsigned CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned W = busy_gen_pkg::cnt_width(CYCLES);
  localparam logic [W-1:0] LAST = W'(CYCLES - 1);

  logic [W-1:0] pre_q;

  generate
    if (CYCLES <= 1) begin : g_every
      assign tick = 1'b1;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pre_q <= '0;
        else        pre_q <= '0;
    end else begin : g_div
      assign tick = (pre_q == LAST);
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
    end
  endgenerate
endmodule

// File: rtl/busy_hold_timer.sv
module busy_hold_timer #(
  parameter int unsigned HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          tick,
  input  logic [HW-1:0] hold_len,
  output logic          active
);
  logic [HW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     left_q <= '0;
    else if (trig)                  left_q <= hold_len;
    else if (tick && left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/busy_leaky_bucket.sv
module busy_leaky_bucket #(
  parameter int unsigned LW = 6,
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          tick,
  input  logic [LW-1:0] limit,
  input  logic [TW-1:0] leak_len,
  output logic          at_limit,
  output logic [LW-1:0] level
);
  logic [LW-1:0] level_q;
  logic [TW-1:0] leak_q;
  logic          enabled, add, drain;
  logic [TW:0]   leak_next;

  assign enabled   = (limit != '0);
  assign leak_next = {1'b0, leak_q} + 1'b1;
  assign add       = trig && enabled && (level_q < limit);
  assign drain     = tick && (level_q != '0) && (leak_next >= {1'b0, leak_len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      leak_q  <= '0;
    end else if (!enabled) begin
      level_q <= '0;
      leak_q  <= '0;
    end else begin
      if (add && !drain)      level_q <= level_q + 1'b1;
      else if (drain && !add) level_q <= level_q - 1'b1;
      if (tick) begin
        if (level_q == '0 || drain) leak_q <= '0;
        else                        leak_q <= leak_next[TW-1:0];
      end
    end
  end

  assign at_limit = enabled && (level_q >= limit);
  assign level    = level_q;
endmodule

// File: rtl/busy_time_counter.sv
module busy_time_counter #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          busy,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (busy) count <= count + 1'b1;
  end
endmodule

// File: rtl/busy_gen.sv
module busy_gen #(
  parameter int unsigned CYCLES_PER_TICK = busy_gen_pkg::TICK_CYCLES_DEFAULT,
  parameter int unsigned HOLD_W  = 16,
  parameter int unsigned BURST_W = 6,
  parameter int unsigned LEAK_W  = 16,
  parameter int unsigned CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_i,
  input  logic               full_i,
  input  logic [HOLD_W-1:0]  cfg_hold_ticks,
  input  logic [BURST_W-1:0] cfg_burst_size,
  input  logic [LEAK_W-1:0]  cfg_leak_ticks,
  input  logic               cnt_clr_i,
  output logic               busy_o,
  output logic [CNT_W-1:0]   busy_cycles_o
);
  logic               tick;
  logic               hold_on;
  logic               burst_on;
  logic [BURST_W-1:0] bucket_level;

  busy_tick_gen #(.CYCLES(CYCLES_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  busy_hold_timer #(.HW(HOLD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .trig(trig_i), .tick(tick),
    .hold_len(cfg_hold_ticks), .active(hold_on)
  );

  busy_leaky_bucket #(.LW(BURST_W), .TW(LEAK_W)) u_bucket (
    .clk(clk), .rst_n(rst_n), .trig(trig_i), .tick(tick),
    .limit(cfg_burst_size), .leak_len(cfg_leak_ticks),
    .at_limit(burst_on), .level(bucket_level)
  );

  assign busy_o = hold_on | full_i | burst_on;

  busy_time_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr_i), .busy(busy_o),
    .count(busy_cycles_o)
  );
endmodule

// File: rtl/busy_gen_chk.sv
module busy_gen_chk #(
  parameter int unsigned HOLD_W  = 16,
  parameter int unsigned BURST_W = 6,
  parameter int unsigned CNT_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               trig_i,
  input logic               full_i,
  input logic [HOLD_W-1:0]  cfg_hold_ticks,
  input logic [BURST_W-1:0] cfg_burst_size,
  input logic               cnt_clr_i,
  input logic               busy_o,
  input logic [CNT_W-1:0]   busy_cycles_o,
  input logic [BURST_W-1:0] level
);
  AST_FULL_FORCES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    full_i |-> busy_o); // R5

  AST_TRIG_OPENS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && cfg_hold_ticks != '0) |=> busy_o); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cnt_clr_i) |=> busy_cycles_o == $past(busy_cycles_o) + 1'b1); // R9

  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !cnt_clr_i) |=> $stable(busy_cycles_o)); // R9

  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_i |=> busy_cycles_o == '0); // R10

  AST_BUCKET_OFF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_burst_size == '0) |=> level == '0); // R8
endmodule

bind busy_gen busy_gen_chk #(.HOLD_W(HOLD_W), .BURST_W(BURST_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .full_i(full_i),
  .cfg_hold_ticks(cfg_hold_ticks), .cfg_burst_size(cfg_burst_size),
  .cnt_clr_i(cnt_clr_i), .busy_o(busy_o), .busy_cycles_o(busy_cycles_o),
  .level(bucket_level)
);

// File: tb/busy_gen_test.sv
module busy_gen_test;
  localparam int TICK = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_i = 1'b0;
  logic        full_i = 1'b0;
  logic [15:0] cfg_hold_ticks = 16'd0;
  logic [5:0]  cfg_burst_size = 6'd0;
  logic [15:0] cfg_leak_ticks = 16'd0;
  logic        cnt_clr_i = 1'b0;
  logic        busy_o;
  logic [31:0] busy_cycles_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  busy_gen #(.CYCLES_PER_TICK(TICK)) uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .full_i(full_i),
    .cfg_hold_ticks(cfg_hold_ticks), .cfg_burst_size(cfg_burst_size),
    .cfg_leak_ticks(cfg_leak_ticks), .cnt_clr_i(cnt_clr_i),
    .busy_o(busy_o), .busy_cycles_o(busy_cycles_o)
  );

  // reference model: plain integers
  int          m_pre = 0;
  int          m_hold = 0;
  int          m_lvl = 0;
  int          m_leak = 0;
  logic [31:0] m_cnt = 0;

  function automatic bit m_busy();
    return (m_hold > 0) || full_i || (cfg_burst_size != 0 && m_lvl >= int'(cfg_burst_size));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= 0; m_hold <= 0; m_lvl <= 0; m_leak <= 0; m_cnt <= 0;
    end else begin
      bit tk, inc, dec;
      tk = (m_pre == TICK - 1);
      m_pre <= tk ? 0 : m_pre + 1;
      if (trig_i) m_hold <= int'(cfg_hold_ticks);
      else if (tk && m_hold > 0) m_hold <= m_hold - 1;
      if (cfg_burst_size == 0) begin
        m_lvl <= 0; m_leak <= 0;
      end else begin
        inc = trig_i && (m_lvl < int'(cfg_burst_size));
        dec = tk && m_lvl > 0 && (m_leak + 1 >= int'(cfg_leak_ticks));
        m_lvl <= m_lvl + int'(inc) - int'(dec);
        if (tk) m_leak <= (m_lvl == 0 || dec) ? 0 : m_leak + 1;
      end
      if (cnt_clr_i) m_cnt <= 0;
      else if (m_busy()) m_cnt <= m_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      check(busy_o == m_busy(), "R2 busy vs model", busy_o, m_busy());
      check(busy_cycles_o == m_cnt, "R9 count vs model", busy_cycles_o, m_cnt);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
  endtask

  task automatic probe(input bit exp_busy, input string req);
    #5;
    check(busy_o == exp_busy, req, busy_o, exp_busy);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    // R1 reset state
    probe(1'b0, "R1 busy after reset");
    check(busy_cycles_o == 0, "R1 count after reset", busy_cycles_o, 0);

    // R4 zero hold
    cfg_hold_ticks = 16'd0;
    pulse_trig();
    probe(1'b0, "R4 zero hold gives no busy");
    step(3);
    probe(1'b0, "R4 still idle");

    // R2 hold window
    cfg_hold_ticks = 16'd3;
    pulse_trig();
    probe(1'b1, "R2 busy after trigger");
    step(4 * TICK + 2);
    probe(1'b0, "R2 busy released after hold");

    // R3 retrigger
    pulse_trig();
    step(2 * TICK);
    pulse_trig();
    step(2 * TICK);
    probe(1'b1, "R3 retrigger extends hold");
    step(3 * TICK);

    // R5 full override
    @(negedge clk); full_i = 1'b1;
    probe(1'b1, "R5 full forces busy");
    step(20);
    probe(1'b1, "R5 full holds busy");
    @(negedge clk); full_i = 1'b0;
    probe(1'b0, "R5 release with full low");

    // R10 clear while busy
    @(negedge clk); full_i = 1'b1;
    step(5);
    cnt_clr_i = 1'b1;
    @(negedge clk); cnt_clr_i = 1'b0;
    #5;
    check(busy_cycles_o == 0, "R10 clear", busy_cycles_o, 0);
    check(busy_o == 1'b1, "R10 busy kept", busy_o, 1);
    @(negedge clk); full_i = 1'b0;

    // R8 limiter disabled
    cfg_hold_ticks = 16'd0;
    cfg_burst_size = 6'd0;
    for (int i = 0; i < 10; i++) pulse_trig();
    probe(1'b0, "R8 disabled limiter no busy");

    // R6 fill to limit, R7 drain
    cfg_burst_size = 6'd3;
    cfg_leak_ticks = 16'd5;
    step(1);
    pulse_trig();
    pulse_trig();
    probe(1'b0, "R6 below limit");
    pulse_trig();
    probe(1'b1, "R6 at limit");
    step(7 * TICK);
    probe(1'b0, "R7 drained below limit");

    // R7 fast leak, several patterns
    cfg_leak_ticks = 16'd0;
    for (int i = 0; i < 6; i++) begin
      pulse_trig();
      step(i);
    end
    step(5 * TICK);
    probe(1'b0, "R7 fast leak empties");
    cfg_burst_size = 6'd1;
    cfg_leak_ticks = 16'd2;
    cfg_hold_ticks = 16'd1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); trig_i = (i % 3 == 0);
      full_i = (i % 7 == 6);
      cnt_clr_i = (i == 17);
    end
    @(negedge clk); trig_i = 1'b0; full_i = 1'b0; cnt_clr_i = 1'b0;
    cfg_burst_size = 6'd0;
    step(4 * TICK);
    probe(1'b0, "R8 limiter off after change");

    step(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule